// File: doc/BRIEF.md
# Switchable Bus Parity Generator and Checker

This block handles parity for a 32-bit bus that carries an address on the first clock of each transfer and data on every following clock. Three mode inputs select the parity scheme. Parity can be turned on or off. The sense can be odd or even. Coverage can be one bit for the whole word or one bit for each byte. The mode is captured at the address cycle and held for the rest of the transfer. Changes made during a burst therefore take effect only when the next transfer begins.

While the bus master drives an address or write data, the block computes the parity bits and asserts the output enables for the bus lines and the parity lines. On read data beats it releases those lines and compares the incoming parity with the data. A mismatch produces a one-clock error strobe and sets a sticky error flag. An external active-high output-disable input forces every line the block drives into high impedance.

Top module: `busParityUnit`

## Requirements
- R1: In byte mode, parity bit i (i = 0..3) covers data bits 8i+7..8i. With parity enabled, the driven bit makes the count of ones in that byte plus the bit even when the sense input is 0 and odd when it is 1.
- R2: In word mode, parity bit 3 covers all 32 data bits with the selected sense. Parity bits 2..0 are never driven: parOe bits 2..0 stay 0.
- R3: With parity disabled, every generated parity bit is 0 and no parity error is ever reported, whatever arrives on parIn.
- R4: adOe and the active parOe bits are 1 in the address cycle and in write data cycles. They are 0 in read data cycles and whenever busCycle is 0.
- R5: While outDisable is 1, adOe and all parOe bits are 0.
- R6: A read data beat with parity enabled and a mismatch on an active parity bit makes parErrStb 1 for exactly the following clock. parErr becomes 1 at the same edge and stays 1 until reset.
- R7: In byte mode, a lane whose active-low byte enable (byteEnN[i]) is 1 never causes an error. In word mode the byte enables have no effect on checking.
- R8: The mode inputs and isWrite are sampled in the cycle where both busCycle and addrCycle are 1. That address cycle uses the new mode, and later changes have no effect until the next address cycle.
- R9: After reset, parErr and parErrStb are 0, and adOe and parOe are 0 while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busCycle | input | 1 | High in every cycle of a bus access |
| addrCycle | input | 1 | High in the address (first) cycle of an access |
| isWrite | input | 1 | Access direction, sampled in the address cycle |
| cfgParEn | input | 1 | Mode: parity enabled |
| cfgParOdd | input | 1 | Mode: 1 = odd sense, 0 = even sense |
| cfgByteMode | input | 1 | Mode: 1 = one bit per byte, 0 = one bit per word |
| outDisable | input | 1 | Forces the bus and parity lines to high impedance |
| busData | input | 32 | Value on the address/data lines |
| byteEnN | input | 4 | Active-low byte enables, bit i for byte i |
| parIn | input | 4 | Parity lines as received |
| parOut | output | 4 | Generated parity |
| parOe | output | 4 | Per-line output enable for the parity lines |
| adOe | output | 1 | Output enable for the address/data lines |
| parErr | output | 1 | Sticky parity error flag |
| parErrStb | output | 1 | One-clock parity error strobe |

## Verification
The embedded properties check on every cycle the rules that depend only on timing and direction. They cover line release under outDisable and during read beats, the three undriven lines in word mode, mode stability inside a transfer, and the strobe-to-flag link: the strobe always follows a check cycle and the flag never falls. Whether each parity value is correct, whether masked lanes are ignored, and whether a mode change is deferred to the next transfer can only be shown by the bench. It sweeps every mode combination over a set of data words and, for reads, over all 16 incoming parity patterns and several byte-enable masks, and compares each result with the count of ones computed in the bench.

// File: rtl/bpPkg.sv
package bpPkg;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic drive;     // block drives address or write data this cycle
    logic check;     // read data beat to be checked
    logic byteMode;  // effective coverage: per byte
    logic oddSense;  // effective sense: odd
    logic enable;    // effective parity enable
  } bpStrobeT;

endpackage

// File: rtl/bpCtrl.sv
module bpCtrl
  import bpPkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busCycle,
  input  logic             addrCycle,
  input  logic             isWrite,
  input  logic             cfgParEn,
  input  logic             cfgParOdd,
  input  logic             cfgByteMode,
  input  logic             outDisable,
  output bpStrobeT         strb,
  output logic             adOe,
  output logic [LANES-1:0] parOe
);

  localparam logic [LANES-1:0] TOP_ONLY = {1'b1, {(LANES-1){1'b0}}};

  logic modeEnQ, modeOddQ, modeByteQ, wrQ;
  logic startCycle;
  logic effEn, effOdd, effByte;

  assign startCycle = busCycle && addrCycle;

  // Mode snapshot taken at each address cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeEnQ   <= 1'b0;
      modeOddQ  <= 1'b0;
      modeByteQ <= 1'b0;
      wrQ       <= 1'b0;
    end else if (startCycle) begin
      modeEnQ   <= cfgParEn;
      modeOddQ  <= cfgParOdd;
      modeByteQ <= cfgByteMode;
      wrQ       <= isWrite;
    end
  end

  // The address cycle itself already uses the new mode
  always_comb begin
    effEn   = startCycle ? cfgParEn    : modeEnQ;
    effOdd  = startCycle ? cfgParOdd   : modeOddQ;
    effByte = startCycle ? cfgByteMode : modeByteQ;
  end

  always_comb begin
    strb.enable   = effEn;
    strb.oddSense = effOdd;
    strb.byteMode = effByte;
    strb.drive    = busCycle && (addrCycle || wrQ);
    strb.check    = busCycle && !addrCycle && !wrQ && effEn;
  end

  always_comb begin
    adOe  = strb.drive && !outDisable;
    parOe = '0;
    if (adOe) begin
      parOe = effByte ? {LANES{1'b1}} : TOP_ONLY;
    end
  end

  // R5
  // R5: outDisable releases every line
  od_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    outDisable |-> (!adOe && parOe == '0));

  // R4
  // R4: read beats and idle cycles leave the lines undriven
  read_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.check || !busCycle) |-> (!adOe && parOe == '0));

  // R2
  // R2: word mode drives only the top parity line
  word_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adOe && !strb.byteMode) |-> (parOe == TOP_ONLY));

  // R8
  // R8: mode snapshot is held inside a transfer
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busCycle && !addrCycle) |=> $stable({modeEnQ, modeOddQ, modeByteQ, wrQ}));

endmodule

// File: rtl/bpData.sv
module bpData
  import bpPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpStrobeT          strb,
  input  logic [DATA_W-1:0] busData,
  input  logic [LANES-1:0]  byteEnN,
  input  logic [LANES-1:0]  parIn,
  output logic [LANES-1:0]  parOut,
  output logic              parErr,
  output logic              parErrStb
);

  logic [LANES-1:0] laneXor;
  logic [LANES-1:0] laneGen;
  logic [LANES-1:0] laneMiss;
  logic             wordGen;
  logic             wordMiss;
  logic             errHit;

  // Per-lane reduction trees
  for (genvar i = 0; i < LANES; i++) begin : gLane
    assign laneXor[i]  = ^busData[i*LANE_W +: LANE_W];
    assign laneGen[i]  = laneXor[i] ^ strb.oddSense;
    assign laneMiss[i] = (laneGen[i] ^ parIn[i]) & ~byteEnN[i];
  end

  assign wordGen  = (^laneXor) ^ strb.oddSense;
  assign wordMiss = wordGen ^ parIn[LANES-1];

  always_comb begin
    parOut = '0;
    if (strb.enable) begin
      if (strb.byteMode) parOut = laneGen;
      else               parOut[LANES-1] = wordGen;
    end
  end

  assign errHit = strb.check && (strb.byteMode ? |laneMiss : wordMiss);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parErrStb <= 1'b0;
      parErr    <= 1'b0;
    end else begin
      parErrStb <= errHit;
      if (errHit) parErr <= 1'b1;
    end
  end

  // R6
  // R6: the strobe always comes with the flag
  stb_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    parErrStb |-> parErr);

  // R6
  // R6: the flag never falls without a reset
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    parErr |=> parErr);

  // R3
  // R3: an error needs a checked beat with parity enabled one cycle earlier
  stb_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parErrStb) |-> ($past(strb.check) && $past(strb.enable)));

endmodule

// File: rtl/busParityUnit.sv
module busParityUnit
  import bpPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCycle,
  input  logic              addrCycle,
  input  logic              isWrite,
  input  logic              cfgParEn,
  input  logic              cfgParOdd,
  input  logic              cfgByteMode,
  input  logic              outDisable,
  input  logic [DATA_W-1:0] busData,
  input  logic [LANES-1:0]  byteEnN,
  input  logic [LANES-1:0]  parIn,
  output logic [LANES-1:0]  parOut,
  output logic [LANES-1:0]  parOe,
  output logic              adOe,
  output logic              parErr,
  output logic              parErrStb
);

  bpStrobeT strb;

  bpCtrl #(.LANES(LANES)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .busCycle    (busCycle),
    .addrCycle   (addrCycle),
    .isWrite     (isWrite),
    .cfgParEn    (cfgParEn),
    .cfgParOdd   (cfgParOdd),
    .cfgByteMode (cfgByteMode),
    .outDisable  (outDisable),
    .strb        (strb),
    .adOe        (adOe),
    .parOe       (parOe)
  );

  bpData #(.DATA_W(DATA_W), .LANE_W(LANE_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busData   (busData),
    .byteEnN   (byteEnN),
    .parIn     (parIn),
    .parOut    (parOut),
    .parErr    (parErr),
    .parErrStb (parErrStb)
  );

endmodule

// File: tb/busParityUnit_test.sv
`timescale 1ns/1ps
module busParityUnit_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busCycle = 1'b0, addrCycle = 1'b0, isWrite = 1'b0;
  logic cfgParEn = 1'b0, cfgParOdd = 1'b0, cfgByteMode = 1'b0;
  logic outDisable = 1'b0;
  logic [31:0] busData = '0;
  logic [3:0] byteEnN = '0, parIn = '0;
  logic [3:0] parOut, parOe;
  logic adOe, parErr, parErrStb;

  int total = 0;
  int failed = 0;
  bit mEn, mOdd, mByte, mWr;
  bit expSticky = 0;

  always #5 clk = ~clk;

  busParityUnit uut (
    .clk(clk), .rstN(rstN), .busCycle(busCycle), .addrCycle(addrCycle),
    .isWrite(isWrite), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .cfgByteMode(cfgByteMode), .outDisable(outDisable), .busData(busData),
    .byteEnN(byteEnN), .parIn(parIn), .parOut(parOut), .parOe(parOe),
    .adOe(adOe), .parErr(parErr), .parErrStb(parErrStb)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Parity bit from a ones count: even sense -> total count even
  function automatic bit parBit(input int ones, input bit odd);
    return ((ones % 2) == 1) ^ odd;
  endfunction

  function automatic logic [3:0] expPar(input logic [31:0] d, input bit en, input bit odd, input bit byt);
    logic [3:0] r = '0;
    if (en) begin
      if (byt) for (int i = 0; i < 4; i++) r[i] = parBit($countones(d[i*8 +: 8]), odd);
      else r[3] = parBit($countones(d), odd);
    end
    return r;
  endfunction

  function automatic bit expMiss(input logic [31:0] d, input logic [3:0] pin, input logic [3:0] ben,
                                 input bit odd, input bit byt);
    logic [3:0] g = expPar(d, 1'b1, odd, byt);
    bit m = 0;
    if (byt) begin
      for (int i = 0; i < 4; i++) if (!ben[i] && pin[i] != g[i]) m = 1;
    end else m = (pin[3] != g[3]);
    return m;
  endfunction

  task automatic beat(input bit first, input bit wr, input logic [31:0] d,
                      input logic [3:0] pin, input logic [3:0] ben, input string tag);
    bit drive, expErr;
    logic [3:0] expOe;
    @(negedge clk);
    busCycle = 1; addrCycle = first; isWrite = wr; busData = d; parIn = pin; byteEnN = ben;
    if (first) begin mEn = cfgParEn; mOdd = cfgParOdd; mByte = cfgByteMode; mWr = wr; end
    drive = first || mWr;
    #1;
    chk(adOe == (drive && !outDisable), {tag, " adOe"}, adOe, drive && !outDisable);
    expOe = (drive && !outDisable) ? (mByte ? 4'hF : 4'h8) : 4'h0;
    chk(parOe == expOe, {tag, " parOe"}, parOe, expOe);
    if (drive) chk(parOut == expPar(d, mEn, mOdd, mByte), {tag, " parOut"}, parOut, expPar(d, mEn, mOdd, mByte));
    expErr = !first && !mWr && mEn && expMiss(d, pin, ben, mOdd, mByte);
    @(posedge clk); #1;
    chk(parErrStb == expErr, {tag, " parErrStb"}, parErrStb, expErr);
    expSticky |= expErr;
    chk(parErr == expSticky, {tag, " parErr"}, parErr, expSticky);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    busCycle = 0; addrCycle = 0; #1;
    chk(!adOe && parOe == 4'h0, {tag, " idle lines"}, {parOe, 3'b0, adOe}, 0);
    @(posedge clk); #1;
    chk(parErrStb == 1'b0, {tag, " idle strobe"}, parErrStb, 0);
  endtask

  function automatic logic [31:0] pat(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0102_0408;
      3: return 32'h8000_0001;
      default: return 32'h9E37_79B9 * k ^ (32'h0F0F_3355 << k);
    endcase
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk(!parErr && !parErrStb, "R9 flags in reset", {parErr, parErrStb}, 0);
    chk(!adOe && parOe == 0, "R9 lines in reset", {parOe, adOe}, 0);
    @(negedge clk); rstN = 1;
    idle("R9");

    // R1 R2 R3 R4: every mode on write transfers
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 6; k++) begin
        cfgParEn = c[0]; cfgParOdd = c[1]; cfgByteMode = c[2];
        beat(1, 1, pat(k + 1), 4'h0, 4'h0, c[2] ? "R1 R4 addr" : "R2 R4 addr");
        beat(0, 1, pat(k), 4'h0, 4'h0, c[0] ? (c[2] ? "R1 wr" : "R2 wr") : "R3 wr");
        beat(0, 1, ~pat(k), 4'h0, 4'h0, "R4 wr");
        idle("R4");
      end
    end

    // R3: disabled reads with wrong parity report nothing
    cfgParEn = 0;
    for (int p = 0; p < 16; p++) begin
      cfgByteMode = p[0];
      beat(1, 0, 32'h1234_5678, 4'h0, 4'h0, "R3 addr");
      beat(0, 0, pat(p % 6), 4'(p), 4'h0, "R3 read");
      idle("R3");
    end

    // R5: forced release during address and write data
    outDisable = 1; cfgParEn = 1; cfgByteMode = 1; cfgParOdd = 0;
    beat(1, 1, 32'hCAFE_0000, 4'h0, 4'h0, "R5 addr");
    beat(0, 1, 32'h0000_00FF, 4'h0, 4'h0, "R5 wr");
    outDisable = 0;
    beat(0, 1, 32'h0000_00FF, 4'h0, 4'h0, "R5 released");
    idle("R5");

    // R8: mode change inside a burst is deferred
    cfgParEn = 1; cfgParOdd = 0; cfgByteMode = 1;
    beat(1, 1, 32'h0000_0100, 4'h0, 4'h0, "R8 addr");
    cfgParOdd = 1; cfgByteMode = 0; isWrite = 0;
    beat(0, 1, 32'h0101_0303, 4'h0, 4'h0, "R8 held");
    chk(parOe == 4'hF, "R8 held byte lines", parOe, 4'hF);
    idle("R8");
    beat(1, 1, 32'h0000_0001, 4'h0, 4'h0, "R8 next xfer");
    chk(parOe == 4'h8, "R8 new word lines", parOe, 4'h8);
    idle("R8");

    // R7: masked lane with bad parity, before any error
    cfgParEn = 1; cfgParOdd = 0; cfgByteMode = 1;
    beat(1, 0, 32'h0, 4'h0, 4'h0, "R7 addr");
    beat(0, 0, 32'h0000_0001, 4'h0, 4'h1, "R7 masked lane");
    beat(0, 0, 32'h0000_0100, 4'h0, 4'hD, "R7 unmasked lane");
    idle("R7");

    // R6 R7: all parity-in patterns over enabled modes and masks
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 6; k++) begin
        for (int m = 0; m < 3; m++) begin
          cfgParEn = 1; cfgParOdd = c[0]; cfgByteMode = c[1];
          beat(1, 0, 32'hA5A5_0000, 4'h0, 4'h0, "R6 addr");
          for (int p = 0; p < 16; p++) begin
            beat(0, 0, pat(k), 4'(p), (m == 0) ? 4'h0 : ((m == 1) ? 4'h5 : 4'hF), "R6 R7 read");
          end
          idle("R6");
        end
      end
    end

    // R6: flag stays set across clean traffic
    cfgParEn = 0;
    beat(1, 1, 32'h0, 4'h0, 4'h0, "R6 sticky");
    idle("R6 sticky");
    chk(parErr == 1'b1, "R6 sticky flag", parErr, 1);

    finishRun();
  end

endmodule